// File: doc/BRIEF.md
# APB Address-Localizing Fanout Decoder

This block sits between one upstream APB4 requester and a set of downstream APB completers. It decodes the upstream address against a parameter map of address windows and raises the select of the one downstream element whose window holds the address. Each window has a base address, an element size and a replication count. A window with a count above one is a one-dimensional array of identical completers placed at successive multiples of the element size.

The selected element does not receive the full upstream address. It receives an address relative to its own element: the upstream address minus the window base, minus the element index times the element size. This value is cut down to log2 of the element size. Completers can therefore decode only their own small register space. Write data, byte strobes and protection bits go to every element unchanged. The read data, ready and error of the selected element are returned upstream. An access that matches no window is completed at once with an error and zero data.

The block is purely combinational. The upstream requester must hold the address and controls stable across the setup and access phases.

Top module: `apbdec_fanout`

## Requirements
- R1: For an upstream access with `s_psel` high, exactly the one element whose window `[base + k*esize, base + (k+1)*esize)` contains `s_paddr` has its `m_psel` bit high. All other `m_psel` bits are low.
- R2: An element's `m_pwrite` bit is high only when that element is selected and `s_pwrite` is high. It is low for every element during reads.
- R3: The selected element's `m_paddr` entry equals `(s_paddr - base) mod esize`. Bits at and above `log2(esize)` in that entry are zero.
- R4: In an arrayed window, the selected element index is `(s_paddr - base) / esize`. Elements are numbered window by window in parameter order, then by array index.
- R5: An element's `m_penable` bit equals `s_penable` when the element is selected and is zero otherwise.
- R6: `m_pwdata`, `m_pstrb` and `m_pprot` equal `s_pwdata`, `s_pstrb` and `s_pprot` for every access, whether or not any element is selected.
- R7: When an element is selected, `s_prdata`, `s_pready` and `s_pslverr` equal that element's `m_prdata`, `m_pready` and `m_pslverr`.
- R8: When `s_psel` is high and no window matches, no `m_psel` bit is set, `s_pready` is 1, `s_pslverr` is 1 and `s_prdata` is zero.
- R9: When `s_psel` is low, no element is selected, `s_pready` is 1, `s_pslverr` is 0 and `s_prdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream access phase |
| s_pwrite | input | 1 | Upstream direction, 1 = write |
| s_paddr | input | ADDR_W | Upstream byte address |
| s_pprot | input | 3 | Upstream protection bits |
| s_pwdata | input | DATA_W | Upstream write data |
| s_pstrb | input | DATA_W/8 | Upstream byte enables |
| s_prdata | output | DATA_W | Read data returned upstream |
| s_pready | output | 1 | Ready returned upstream |
| s_pslverr | output | 1 | Error returned upstream |
| m_psel | output | NELEM | Per-element select |
| m_penable | output | NELEM | Per-element access phase |
| m_pwrite | output | NELEM | Per-element write direction |
| m_paddr | output | NELEM x LOC_W | Per-element local address, zero above the element's own width |
| m_pprot | output | 3 | Broadcast protection bits |
| m_pwdata | output | DATA_W | Broadcast write data |
| m_pstrb | output | DATA_W/8 | Broadcast byte enables |
| m_prdata | input | NELEM x DATA_W | Per-element read data |
| m_pready | input | NELEM | Per-element ready |
| m_pslverr | input | NELEM | Per-element error |

## Verification
The bench sweeps every word address of the 4 KiB default space, for reads and writes, in both the setup and the access phase. This covers the first and last word of every window and array element, and the holes between windows. A decoder that used a closed upper bound would select an element one stride too far, or hit in a hole. A decoder that forgot the array offset would send the raw window offset to elements 2 to 4, which then exceeds their 6-bit width. Truncating to the wrong width would leave nonzero high bits in the narrow windows. The completer responses vary with the address, so a return mux that picks the wrong element, or a default path that leaves the error low, shows up as a data, ready or error mismatch.

// File: rtl/apbdec_pkg.sv
package apbdec_pkg;
  localparam int PROT_W = 3;
  localparam int MAX_WIN = 8;

  typedef int unsigned win_tbl_t [MAX_WIN];

  // number of elements in windows below index w
  function automatic int unsigned elems_below(win_tbl_t cnt, int unsigned w);
    int unsigned s;
    s = 0;
    for (int unsigned j = 0; j < MAX_WIN; j++)
      if (j < w) s += cnt[j];
    return s;
  endfunction
endpackage

// File: rtl/apbdec_match.sv
module apbdec_match #(
  parameter int ADDR_W = 12,
  parameter int LOC_W = 8,
  parameter int unsigned EBASE = 0,
  parameter int unsigned ESIZE = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LOC_W-1:0]  loc
);
  localparam int LW = (ESIZE > 1) ? $clog2(ESIZE) : 1;
  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(EBASE);
  localparam logic [ADDR_W:0] SIZE_X = (ADDR_W+1)'(ESIZE);

  logic [ADDR_W:0] diff;

  always_comb begin
    diff = {1'b0, addr} - BASE_X;
    hit  = !diff[ADDR_W] && (diff < SIZE_X);
    loc  = '0;
    loc[LW-1:0] = diff[LW-1:0];
  end
endmodule

// File: rtl/apbdec_ret.sv
module apbdec_ret #(
  parameter int NELEM = 6,
  parameter int DATA_W = 32
) (
  input  logic                         req,
  input  logic [NELEM-1:0]             sel,
  input  logic [NELEM-1:0][DATA_W-1:0] e_rdata,
  input  logic [NELEM-1:0]             e_ready,
  input  logic [NELEM-1:0]             e_err,
  output logic [DATA_W-1:0]            rdata,
  output logic                         ready,
  output logic                         err
);
  logic any;

  always_comb begin
    any   = |sel;
    rdata = '0;
    ready = 1'b0;
    err   = 1'b0;
    for (int e = 0; e < NELEM; e++) begin
      if (sel[e]) begin
        rdata = rdata | e_rdata[e];
        ready = ready | e_ready[e];
        err   = err | e_err[e];
      end
    end
    if (!any) begin
      ready = 1'b1;
      err   = req;
    end
  end
endmodule

// File: rtl/apbdec_fanout.sv
module apbdec_fanout
  import apbdec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NWIN = 3,
  parameter win_tbl_t WIN_BASE  = '{32'h000, 32'h200, 32'h400, 0, 0, 0, 0, 0},
  parameter win_tbl_t WIN_ESIZE = '{32'h100, 32'h040, 32'h010, 1, 1, 1, 1, 1},
  parameter win_tbl_t WIN_COUNT = '{1, 4, 1, 0, 0, 0, 0, 0},
  parameter int NELEM = 6,
  parameter int LOC_W = 8
) (
  input  logic                         s_psel,
  input  logic                         s_penable,
  input  logic                         s_pwrite,
  input  logic [ADDR_W-1:0]            s_paddr,
  input  logic [PROT_W-1:0]            s_pprot,
  input  logic [DATA_W-1:0]            s_pwdata,
  input  logic [DATA_W/8-1:0]          s_pstrb,
  output logic [DATA_W-1:0]            s_prdata,
  output logic                         s_pready,
  output logic                         s_pslverr,
  output logic [NELEM-1:0]             m_psel,
  output logic [NELEM-1:0]             m_penable,
  output logic [NELEM-1:0]             m_pwrite,
  output logic [NELEM-1:0][LOC_W-1:0]  m_paddr,
  output logic [PROT_W-1:0]            m_pprot,
  output logic [DATA_W-1:0]            m_pwdata,
  output logic [DATA_W/8-1:0]          m_pstrb,
  input  logic [NELEM-1:0][DATA_W-1:0] m_prdata,
  input  logic [NELEM-1:0]             m_pready,
  input  logic [NELEM-1:0]             m_pslverr
);
  localparam int unsigned ELEM_SUM = elems_below(WIN_COUNT, NWIN);

  if (ELEM_SUM != NELEM) begin : g_bad_nelem
    $error("NELEM does not match the window counts");
  end

  logic [NELEM-1:0] hit;
  logic [NELEM-1:0] wr_sel;
  logic [NELEM-1:0] rd_sel;

  // one address matcher per array element
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    for (genvar k = 0; k < int'(WIN_COUNT[w]); k++) begin : g_elem
      localparam int unsigned IDX = elems_below(WIN_COUNT, w) + k;
      localparam int unsigned EB  = WIN_BASE[w] + k * WIN_ESIZE[w];
      if ($clog2(WIN_ESIZE[w]) > LOC_W) begin : g_bad_w
        $error("LOC_W too narrow for a window");
      end
      apbdec_match #(
        .ADDR_W(ADDR_W), .LOC_W(LOC_W), .EBASE(EB), .ESIZE(WIN_ESIZE[w])
      ) match_i (
        .addr(s_paddr),
        .hit (hit[IDX]),
        .loc (m_paddr[IDX])
      );
    end
  end

  always_comb begin
    wr_sel    = hit & {NELEM{s_psel &  s_pwrite}};
    rd_sel    = hit & {NELEM{s_psel & ~s_pwrite}};
    m_psel    = wr_sel | rd_sel;
    m_pwrite  = wr_sel;
    m_penable = m_psel & {NELEM{s_penable}};
    m_pprot   = s_pprot;
    m_pwdata  = s_pwdata;
    m_pstrb   = s_pstrb;
  end

  apbdec_ret #(.NELEM(NELEM), .DATA_W(DATA_W)) ret_i (
    .req    (s_psel),
    .sel    (m_psel),
    .e_rdata(m_prdata),
    .e_ready(m_pready),
    .e_err  (m_pslverr),
    .rdata  (s_prdata),
    .ready  (s_pready),
    .err    (s_pslverr)
  );
endmodule

// File: rtl/apbdec_fanout_chk.sv
module apbdec_fanout_chk #(
  parameter int NELEM = 6,
  parameter int DATA_W = 32
) (
  input logic              s_psel,
  input logic              s_penable,
  input logic              s_pwrite,
  input logic [DATA_W-1:0] s_prdata,
  input logic              s_pready,
  input logic              s_pslverr,
  input logic [NELEM-1:0]  m_psel,
  input logic [NELEM-1:0]  m_penable,
  input logic [NELEM-1:0]  m_pwrite,
  input logic [NELEM-1:0]  m_pready
);
  always_comb begin
    if (!$isunknown({s_psel, s_penable, s_pwrite, m_psel, m_penable, m_pwrite, m_pready})) begin
      p_one_select_r1: assert ($onehot0(m_psel));
      p_write_only_sel_r2: assert ((m_pwrite & ~m_psel) == '0);
      p_no_write_on_read_r2: assert (s_pwrite || m_pwrite == '0);
      p_enable_only_sel_r5: assert ((m_penable & ~m_psel) == '0);
      p_enable_follows_r5: assert (s_penable || m_penable == '0);
      p_ready_from_sel_r7: assert (m_psel == '0 || s_pready == |(m_psel & m_pready));
      p_unmapped_err_r8: assert (!(s_psel && m_psel == '0) || (s_pready && s_pslverr && s_prdata == '0));
      p_idle_quiet_r9: assert (s_psel || (m_psel == '0 && s_pready && !s_pslverr));
    end
  end
endmodule

bind apbdec_fanout apbdec_fanout_chk #(.NELEM(NELEM), .DATA_W(DATA_W)) chk_i (
  .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
  .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr),
  .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite), .m_pready(m_pready)
);

// File: tb/apbdec_fanout_tb_top.sv
module apbdec_fanout_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NE = 6;
  localparam int LW = 8;

  logic clk;
  logic rst_n;
  logic s_psel, s_penable, s_pwrite;
  logic [AW-1:0] s_paddr;
  logic [2:0] s_pprot;
  logic [DW-1:0] s_pwdata;
  logic [3:0] s_pstrb;
  logic [DW-1:0] s_prdata;
  logic s_pready, s_pslverr;
  logic [NE-1:0] m_psel, m_penable, m_pwrite;
  logic [NE-1:0][LW-1:0] m_paddr;
  logic [2:0] m_pprot;
  logic [DW-1:0] m_pwdata;
  logic [3:0] m_pstrb;
  logic [NE-1:0][DW-1:0] m_prdata;
  logic [NE-1:0] m_pready, m_pslverr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  apbdec_fanout dut_i (.*);

  // completer responses vary with address and element
  always_comb begin
    for (int e = 0; e < NE; e++) begin
      m_prdata[e]  = 32'hC0DE_0000 + e * 32'h111 + {20'd0, s_paddr};
      m_pready[e]  = s_paddr[2] ^ e[0];
      m_pslverr[e] = s_paddr[3] ^ e[1];
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, s_paddr, act, exp);
    end
  endtask

  // expected map, written from the requirements
  task automatic expect_map(input int a, output int e, output int loc);
    e = -1; loc = 0;
    if (a < 'h100) begin e = 0; loc = a; end
    else if (a >= 'h200 && a < 'h300) begin e = 1 + (a - 'h200) / 'h40; loc = (a - 'h200) % 'h40; end
    else if (a >= 'h400 && a < 'h410) begin e = 5; loc = a - 'h400; end
  endtask

  task automatic check_now(input bit sel, input bit en, input bit wr);
    int e, loc;
    logic [NE-1:0] exp_sel;
    expect_map(int'(s_paddr), e, loc);
    exp_sel = '0;
    if (sel && e >= 0) exp_sel[e] = 1'b1;
    if (e >= 1 && e <= 4) chk(m_psel == exp_sel, "R4", m_psel, exp_sel);
    else chk(m_psel == exp_sel, "R1", m_psel, exp_sel);
    chk(m_pwrite == (wr ? exp_sel : '0), "R2", m_pwrite, wr ? exp_sel : '0);
    chk(m_penable == (en ? exp_sel : '0), "R5", m_penable, en ? exp_sel : '0);
    chk(m_pwdata == s_pwdata && m_pstrb == s_pstrb && m_pprot == s_pprot, "R6",
        {m_pprot, m_pstrb, m_pwdata}, {s_pprot, s_pstrb, s_pwdata});
    if (sel && e >= 0) begin
      chk(m_paddr[e] == LW'(loc), "R3", m_paddr[e], loc);
      chk(s_prdata == 32'hC0DE_0000 + e * 32'h111 + {20'd0, s_paddr} &&
          s_pready == (s_paddr[2] ^ e[0]) && s_pslverr == (s_paddr[3] ^ e[1]), "R7",
          {s_pready, s_pslverr, s_prdata},
          {(s_paddr[2] ^ e[0]), (s_paddr[3] ^ e[1]), 32'hC0DE_0000 + e * 32'h111 + {20'd0, s_paddr}});
    end else if (sel) begin
      chk(s_pready && s_pslverr && s_prdata == '0, "R8",
          {s_pready, s_pslverr, s_prdata}, {1'b1, 1'b1, 32'd0});
    end else begin
      chk(s_pready && !s_pslverr && s_prdata == '0, "R9",
          {s_pready, s_pslverr, s_prdata}, {1'b1, 1'b0, 32'd0});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    s_psel = 0; s_penable = 0; s_pwrite = 0; s_paddr = '0;
    s_pprot = '0; s_pwdata = '0; s_pstrb = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 check_now(0, 0, 0); // idle state, R9
    for (int a = 0; a < 4096; a += 4) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        s_paddr = AW'(a); s_pwrite = w[0]; s_psel = 1; s_penable = 0;
        s_pprot = 3'(a >> 2); s_pwdata = 32'h5A00_0000 ^ a; s_pstrb = 4'(a >> 4);
        #1 check_now(1, 0, w[0]);
        @(negedge clk);
        s_penable = 1;
        #1 check_now(1, 1, w[0]);
      end
      if (a % 256 == 0) begin
        @(negedge clk);
        s_psel = 0; s_penable = 1; s_pwrite = 1;
        #1 check_now(0, 1, 1); // select low ignores other controls, R9
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule